// File: doc/BRIEF.md
# One-Time-Programmable Memory Command Controller

This block puts a one-time-programmable (OTP) word array behind a small set of 32-bit registers. Software places a target address in the address register and then writes a 32-bit command word to the command register. Three exact command words are recognised: a read that copies array words into the data registers, a mode-select write that only checks its address against a short list of accepted values, and a program that merges the first data register into one array word. While an operation runs, two idle flags in the status register are low, and a sticky error flag reports whether the command failed.

The array holds 4096 words by default. Its lower half is the data region, where a read returns two consecutive words. Its upper half is the configuration region, where a read returns a single word. Programming can only turn bits from 0 to 1. A read-only protection register returns a fixed value. Register reads are combinational on the address port.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset, the status register at offset 0x014 reads 0x3, and the data registers at 0x020 and 0x024 and the address register at 0x010 read 0. The protection register at 0x000 reads PROT_INIT, and writes to it are ignored.
- R2: Only these command words start an operation when written to offset 0x004: read 0x23B1E361, mode-select 0x23B1E362 and program 0x23B1E364. Any other value changes no data register and no array word, sets the error flag, and the controller is idle again one cycle later.
- R3: Status bit 0 is the controller idle flag, bit 1 is the array idle flag and bit 2 is the error flag. An accepted command clears both idle flags, and both are set when the command completes. A command write that arrives while the controller is busy is dropped.
- R4: A read whose word address N is below DWORDS/2 loads word N into the first data register and word N+1 into the second, and keeps the controller busy for 4 cycles.
- R5: A read whose word address lies from DWORDS/2 to DWORDS-1 loads only the first data register, leaves the second unchanged, and keeps the controller busy for 2 cycles.
- R6: A read at a word address of DWORDS or above changes neither data register, sets the error flag and is busy for 1 cycle.
- R7: A mode-select write succeeds, with the error flag clear, for addresses 0, 0x1000, 0x3000 and 0x5000. Any other address sets the error flag. In every case no array word changes, and the controller is busy for 1 cycle.
- R8: A program takes the address register as a byte offset and ignores its two low bits. It ORs the first data register into that word and keeps the controller busy for PROG_CYCLES cycles. An offset of DWORDS*4 or above changes nothing, sets the error flag and is busy for 1 cycle.
- R9: The error flag is cleared when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
A register write takes effect at the rising edge on which the strobe is high. The bench therefore reads back registers half a cycle later, after it has moved the address port. After a command write, the bench samples the status register at every following falling edge and counts the samples that show the idle flags low. That count must be 1 for rejected, unknown and mode-select commands, 2 for a configuration read, 4 for a data read and PROG_CYCLES for a program. Data registers and the error flag are compared only after idle returns, against a word-array model kept in the bench.

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl #(
  parameter int          DWORDS      = 4096,
  parameter int          PROG_CYCLES = 8,   // must be at least 2
  parameter logic [31:0] PROT_INIT   = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int IW         = $clog2(DWORDS);
  localparam int CW         = $clog2(PROG_CYCLES + 1);
  localparam int DATA_WORDS = DWORDS / 2;
  localparam int BYTES      = DWORDS * 4;

  localparam logic [11:0] OFS_PROT = 12'h000;
  localparam logic [11:0] OFS_CMD  = 12'h004;
  localparam logic [11:0] OFS_ADDR = 12'h010;
  localparam logic [11:0] OFS_STAT = 12'h014;
  localparam logic [11:0] OFS_D0   = 12'h020;
  localparam logic [11:0] OFS_D1   = 12'h024;

  localparam logic [31:0] CMD_RD   = 32'h23B1_E361;
  localparam logic [31:0] CMD_MODE = 32'h23B1_E362;
  localparam logic [31:0] CMD_PG   = 32'h23B1_E364;

  typedef enum logic [2:0] {S_IDLE, S_FIN, S_RA, S_RB, S_RC, S_RD, S_PG} st_t;

  st_t            st;
  logic [31:0]    addr_q, data0, data1;
  logic           err_q, cfg_q;
  logic [IW-1:0]  op_idx, rd_idx;
  logic [CW-1:0]  cnt;
  logic [31:0]    q;
  logic [31:0]    mem [DWORDS];

  wire busy    = (st != S_IDLE);
  wire cmd_wr  = bus_wr && (bus_addr == OFS_CMD);
  wire cmd_go  = cmd_wr && !busy;
  wire rd_ok   = addr_q < 32'(DWORDS);
  wire rd_data = addr_q < 32'(DATA_WORDS);
  wire wr_ok   = (addr_q == 32'h0) || (addr_q == 32'h1000) ||
                 (addr_q == 32'h3000) || (addr_q == 32'h5000);
  wire pg_ok   = addr_q < 32'(BYTES);
  wire pg_last = (st == S_PG) && (cnt == CW'(PROG_CYCLES - 1));

  assign rd_idx = (st == S_RC || st == S_RD) ? op_idx + IW'(1) : op_idx;

  initial begin
    for (int i = 0; i < DWORDS; i++) mem[i] = 32'h0;
  end

  always_ff @(posedge clk) begin
    q <= mem[rd_idx];
    if (pg_last) mem[op_idx] <= q | data0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      data0  <= '0;
      data1  <= '0;
      err_q  <= 1'b0;
      cfg_q  <= 1'b0;
      op_idx <= '0;
      cnt    <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          OFS_ADDR: addr_q <= bus_wdata;
          OFS_D0:   data0  <= bus_wdata;
          OFS_D1:   data1  <= bus_wdata;
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (cmd_go) begin
          err_q  <= 1'b0;
          cfg_q  <= !rd_data;
          op_idx <= addr_q[IW-1:0];
          cnt    <= '0;
          case (bus_wdata)
            CMD_RD: if (rd_ok) st <= S_RA;
                    else begin err_q <= 1'b1; st <= S_FIN; end
            CMD_MODE: begin err_q <= !wr_ok; st <= S_FIN; end
            CMD_PG: if (pg_ok) begin op_idx <= addr_q[IW+1:2]; st <= S_PG; end
                    else begin err_q <= 1'b1; st <= S_FIN; end
            default: begin err_q <= 1'b1; st <= S_FIN; end
          endcase
        end
        S_FIN: st <= S_IDLE;
        S_RA:  st <= S_RB;
        S_RB:  begin data0 <= q; st <= cfg_q ? S_IDLE : S_RC; end
        S_RC:  st <= S_RD;
        S_RD:  begin data1 <= q; st <= S_IDLE; end
        S_PG:  begin cnt <= cnt + CW'(1); if (pg_last) st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_PROT: bus_rdata = PROT_INIT;
      OFS_STAT: bus_rdata = {29'h0, err_q, !busy, !busy};
      OFS_ADDR: bus_rdata = addr_q;
      OFS_D0:   bus_rdata = data0;
      OFS_D1:   bus_rdata = data1;
      default:  bus_rdata = 32'h0;
    endcase
  end

  AST_START_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> busy); // R3
  AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && st == S_PG && cnt == '0) |=> (st == S_PG)); // R3
  AST_UNKNOWN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && bus_wdata != CMD_RD && bus_wdata != CMD_MODE && bus_wdata != CMD_PG)
    |=> (err_q && st == S_FIN)); // R2
  AST_REJECT_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && bus_wdata == CMD_RD && !rd_ok) |=> ($stable(data0) && $stable(data1) && err_q)); // R6
  AST_CFG_KEEPS_D1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RB && cfg_q && !bus_wr) |=> ($stable(data1) && !busy)); // R5
  AST_MODE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && bus_wdata == CMD_MODE) |=> (st == S_FIN)); // R7
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && bus_wdata == CMD_MODE && addr_q == 32'h0) |=> !err_q); // R9
endmodule

// File: tb/otp_cmd_ctrl_bench.sv
module otp_cmd_ctrl_bench;
  localparam int          PC  = 8;
  localparam int          NW  = 4096;
  localparam logic [31:0] PV  = 32'hA5C3_0F1E;
  localparam logic [31:0] C_RD = 32'h23B1_E361, C_MD = 32'h23B1_E362, C_PG = 32'h23B1_E364;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = 12'h0;
  logic [31:0] bus_wdata = 32'h0, bus_rdata;
  logic [31:0] ref_mem [NW];
  logic [31:0] r_d0 = 32'h0, r_d1 = 32'h0;
  int checks = 0, fails = 0;

  otp_cmd_ctrl #(.DWORDS(NW), .PROG_CYCLES(PC), .PROT_INIT(PV)) u_otp_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic issue(input logic [31:0] code, input logic [31:0] drop_code, output int n);
    logic [31:0] s;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = code;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      rd(12'h014, s);
      if (s[0]) break;
      n++;
      if (n == 1 && drop_code != 32'h0) begin
        bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = drop_code;
      end
    end
  endtask

  task automatic post(input string req, input logic e);
    logic [31:0] v;
    rd(12'h014, v); chk(req, v, {29'h0, e, 2'b11});
    rd(12'h020, v); chk(req, v, r_d0);
    rd(12'h024, v); chk(req, v, r_d1);
  endtask

  task automatic do_read(input logic [31:0] a);
    int n; string req;
    req = (a < NW/2) ? "R4" : (a < NW) ? "R5" : "R6";
    wr(12'h010, a);
    issue(C_RD, 32'h0, n);
    if (a < NW) r_d0 = ref_mem[a];
    if (a < NW/2) r_d1 = ref_mem[a+1];
    chk(req, n, (a < NW/2) ? 4 : (a < NW) ? 2 : 1);
    post(req, a >= NW);
  endtask

  task automatic do_mode(input logic [31:0] a);
    int n; logic ok;
    ok = (a == 0) || (a == 32'h1000) || (a == 32'h3000) || (a == 32'h5000);
    wr(12'h010, a);
    issue(C_MD, 32'h0, n);
    chk("R7", n, 1);
    post("R7", !ok);
  endtask

  task automatic do_prog(input logic [31:0] a, input logic [31:0] v, input logic [31:0] drop);
    int n; logic ok;
    ok = a < NW*4;
    wr(12'h020, v); r_d0 = v;
    wr(12'h010, a);
    issue(C_PG, drop, n);
    if (ok) ref_mem[a[13:2]] = ref_mem[a[13:2]] | v;
    chk(drop != 0 ? "R3" : "R8", n, ok ? PC : 1);
    post("R8", !ok);
  endtask

  task automatic do_unknown(input logic [31:0] c);
    int n;
    issue(c, 32'h0, n);
    chk("R2", n, 1);
    post("R2", 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    int seed;
    for (int i = 0; i < NW; i++) ref_mem[i] = 32'h0;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(12'h014, v); chk("R1", v, 32'h3);
    rd(12'h020, v); chk("R1", v, 32'h0);
    rd(12'h024, v); chk("R1", v, 32'h0);
    rd(12'h010, v); chk("R1", v, 32'h0);
    rd(12'h000, v); chk("R1", v, PV);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R1", v, PV);

    do_prog(32'h0000_0010, 32'h0000_00F0, 32'h0);
    do_prog(32'h0000_0013, 32'h0000_0F00, 32'h0);
    do_read(32'h4);
    do_read(32'h5);
    do_prog(32'h0000_1FFC, 32'h1234_5678, 32'h0);
    do_prog(32'h0000_2002, 32'hCAFE_0001, 32'h0);
    do_read(32'h7FF);
    do_read(32'h800);
    do_read(32'hFFF);
    do_read(32'h1000);
    do_read(32'hFFFF_FFFF);
    do_prog(32'h0000_4000, 32'hFFFF_FFFF, 32'h0);
    do_read(32'hFFF);
    do_mode(32'h1000);
    do_read(32'h400);
    do_mode(32'h2000);
    do_mode(32'h0);      // R9: error from the previous command is cleared
    do_mode(32'h3000);
    do_mode(32'h5000);
    do_mode(32'h1);
    do_unknown(32'h23B1_E363);
    do_unknown(32'h0);
    do_prog(32'h0000_0020, 32'h0000_0001, C_RD);
    do_read(32'h8);

    for (int k = 0; k < 50; k++) begin
      case ($urandom % 4)
        0: do_prog($urandom % 32'h4400, $urandom, 32'h0);
        1: do_read($urandom % 32'h1100);
        2: begin
          a = $urandom % 6;
          do_mode(a == 0 ? 32'h0 : a == 1 ? 32'h1000 : a == 2 ? 32'h3000 :
                  a == 3 ? 32'h5000 : $urandom % 32'h6000);
        end
        default: begin
          v = $urandom;
          if (v == C_RD || v == C_MD || v == C_PG) v = v ^ 32'h8;
          do_unknown(v);
        end
      endcase
    end
    for (int k = 0; k < 8; k++) do_read($urandom % NW);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule